// File: doc/BRIEF.md
# Temperature-Aware DRAM Refresh Governor

This controller-side block sets how often refresh commands are requested from a DRAM, and whether self-refresh may be entered. It watches a case-temperature reading in whole degrees Celsius, plus the two mode-register settings that the controller has programmed: automatic self-refresh handling and the self-refresh extended-range flag. When the reading is 85 °C or below, it paces refresh at the normal interval, so that every row is covered in a 64 ms window. Above 85 °C it halves the interval, which covers every row in 32 ms.

Self-refresh is allowed above 85 °C only when one of the two mode settings covers the hotter range. Readings above 95 °C lie outside the supported window. They block self-refresh and set a sticky error flag. The block also gives the mode-register bit values it recommends. The extended-range bit is recommended only for manual mode on a hot die, and is never recommended while automatic mode is on.

The normal interval, in clocks, is floor(CLK_KHZ × PERIOD_MS / CMDS_PER_PERIOD). The fast interval is half of it, rounded down.

Top module: `refresh_governor`

## Requirements
- R1: While rst_n is low and in the first cycle after its release, ref_tick, fast_rate and over_range are 0. The first ref_tick is seen NORM clocks after the release.
- R2: While fast_rate is 0, ref_tick is a one-clock pulse that repeats every NORM clocks. The gap between two pulses never exceeds NORM clocks.
- R3: While fast_rate stays 1, ref_tick repeats every FAST = NORM/2 clocks.
- R4: Suppose temp_c goes above 85 and is first sampled at the j-th clock after a normal-rate pulse, for 1 ≤ j < NORM. The next pulse then comes min(NORM, j + FAST + 1) clocks after the previous one, so the running countdown is shortened and no deadline is missed.
- R5: Suppose temp_c drops to 85 or below during a fast interval. That interval still ends at its fast length, and the intervals after it are NORM long.
- R6: fast_rate is 1 exactly when the temp_c value sampled at the previous clock edge is greater than 85, so 85 itself counts as normal.
- R7: sr_permit is 0 when the sampled temperature is above 95. It is also 0 when the sampled temperature is above 85 while both asr_en and srt_en are 0. In every other case it is 1.
- R8: rec_asr follows asr_en. rec_srt is 0 whenever asr_en is 1; otherwise rec_srt equals fast_rate.
- R9: over_range goes to 1 one clock after a temp_c value above 95 is sampled. It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| temp_c | input | TEMP_W | Case temperature in °C, unsigned |
| asr_en | input | 1 | Programmed automatic self-refresh mode bit |
| srt_en | input | 1 | Programmed extended-range self-refresh bit |
| ref_tick | output | 1 | One-clock refresh request pulse |
| fast_rate | output | 1 | Doubled refresh rate in effect (hot) |
| sr_permit | output | 1 | Self-refresh entry allowed |
| over_range | output | 1 | Sticky: temperature exceeded 95 °C |
| rec_asr | output | 1 | Recommended automatic self-refresh bit |
| rec_srt | output | 1 | Recommended extended-range bit |

## Verification
The riskiest corner is a rise in temperature at each possible phase of a normal interval. If the design only switched rates at the next reload, it would overrun the 32 ms deadline, which shows as a gap of NORM where a shorter one is expected. If it restarted the count outright, the gaps would come out wrong at the late phases. The bench also cools the die in the middle of a fast interval: a design that stretches the running interval would produce a gap longer than FAST.

A near-exhaustive sweep of temperatures 0 to 120, crossed with all four mode-bit combinations, probes the off-by-one limits at 85/86 and 95/96. A design with a wrong comparison would flip fast_rate or sr_permit at exactly those readings. The sweep also confirms that over_range stays set after cooling and clears only on reset.

// File: rtl/refresh_gov_pkg.sv
// Package: shared types for the refresh governor.
// Assumes temperatures are unsigned whole degrees Celsius.
package refresh_gov_pkg;

    // Registered temperature classification
    typedef struct packed {
        logic hot;    // above the refresh-doubling limit
        logic over;   // above the supported window
    } temp_zone_t;

    // Interval length in clocks for a given clock and refresh budget
    function automatic int unsigned norm_interval(int unsigned clk_khz,
                                                  int unsigned period_ms,
                                                  int unsigned cmds);
        return (clk_khz * period_ms) / cmds;
    endfunction

endpackage

// File: rtl/temp_zone_reg.sv
// Module: temp_zone_reg
// Samples the temperature each clock and classifies it against the hot
// and maximum limits. Also keeps a sticky out-of-window error.
// Assumes: limits are constants, HOT_C < MAX_C, reset synchronous active-low.
module temp_zone_reg
    import refresh_gov_pkg::*;
#(
    parameter int unsigned TEMP_W = 8,
    parameter int unsigned HOT_C  = 85,
    parameter int unsigned MAX_C  = 95
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_c,
    output temp_zone_t        zone,
    output logic              err_sticky
);
    localparam logic [TEMP_W-1:0] HOT_LIM = TEMP_W'(HOT_C);
    localparam logic [TEMP_W-1:0] MAX_LIM = TEMP_W'(MAX_C);

    temp_zone_t zone_d;

    // Purpose: classify the live reading against both limits
    always_comb begin
        zone_d.hot  = (temp_c > HOT_LIM);
        zone_d.over = (temp_c > MAX_LIM);
    end

    // Purpose: register the zone and accumulate the sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zone       <= '0;
            err_sticky <= 1'b0;
        end else begin
            zone       <= zone_d;
            err_sticky <= err_sticky | zone_d.over;
        end
    end
endmodule

// File: rtl/refresh_pacer.sv
// Module: refresh_pacer
// Down-counter that emits a one-clock tick at each interval boundary.
// It reloads with the normal or fast length, depending on the hot flag
// at that boundary. While hot, a longer pending countdown is clamped to
// the fast length, so the tighter deadline is never missed.
// Assumes: NORM_TICKS >= 2, FAST_TICKS >= 1, FAST_TICKS <= NORM_TICKS.
module refresh_pacer #(
    parameter int unsigned NORM_TICKS = 976,
    parameter int unsigned FAST_TICKS = 488
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hot,
    output logic tick
);
    localparam int unsigned CW = (NORM_TICKS > 1) ? $clog2(NORM_TICKS) : 1;
    localparam logic [CW-1:0] NORM_LOAD = CW'(NORM_TICKS - 1);
    localparam logic [CW-1:0] FAST_LOAD = CW'(FAST_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_dec;

    // Purpose: next countdown value, clamped when running hot
    always_comb begin
        cnt_dec = cnt_q - 1'b1;
        if (hot && (cnt_dec > FAST_LOAD)) begin
            cnt_dec = FAST_LOAD;
        end
    end

    // Purpose: count down, pulse at zero and reload per current rate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= NORM_LOAD;
            tick  <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q <= hot ? FAST_LOAD : NORM_LOAD;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_dec;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/sr_policy.sv
// Module: sr_policy
// Decides whether self-refresh entry is allowed, and the mode-register
// bit values to recommend, from the registered zone and the programmed
// mode bits.
// Assumes: mode bits are quasi-static and already in the clock domain.
module sr_policy
    import refresh_gov_pkg::*;
(
    input  temp_zone_t zone,
    input  logic       asr_en,
    input  logic       srt_en,
    output logic       permit,
    output logic       rec_asr,
    output logic       rec_srt
);
    // Purpose: gate self-refresh and derive recommended mode bits
    always_comb begin
        permit  = !zone.over && (!zone.hot || asr_en || srt_en);
        rec_asr = asr_en;
        rec_srt = !asr_en && zone.hot;
    end
endmodule

// File: rtl/refresh_governor.sv
// Module: refresh_governor (top)
// Paces refresh requests at a normal or doubled rate from case
// temperature, gates self-refresh on the programmed mode bits, flags
// out-of-window readings and recommends mode-register bit values.
// Assumes: clock frequency given in kHz, synchronous active-low reset.
module refresh_governor
    import refresh_gov_pkg::*;
#(
    parameter int unsigned CLK_KHZ         = 125000,
    parameter int unsigned PERIOD_MS       = 64,
    parameter int unsigned CMDS_PER_PERIOD = 8192,
    parameter int unsigned TEMP_W          = 8,
    parameter int unsigned HOT_C           = 85,
    parameter int unsigned MAX_C           = 95
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_c,
    input  logic              asr_en,
    input  logic              srt_en,
    output logic              ref_tick,
    output logic              fast_rate,
    output logic              sr_permit,
    output logic              over_range,
    output logic              rec_asr,
    output logic              rec_srt
);
    localparam int unsigned NORM_TICKS = norm_interval(CLK_KHZ, PERIOD_MS, CMDS_PER_PERIOD);
    localparam int unsigned FAST_TICKS = NORM_TICKS / 2;

    temp_zone_t zone;

    temp_zone_reg #(
        .TEMP_W (TEMP_W),
        .HOT_C  (HOT_C),
        .MAX_C  (MAX_C)
    ) u_zone (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_c     (temp_c),
        .zone       (zone),
        .err_sticky (over_range)
    );

    refresh_pacer #(
        .NORM_TICKS (NORM_TICKS),
        .FAST_TICKS (FAST_TICKS)
    ) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .hot   (zone.hot),
        .tick  (ref_tick)
    );

    sr_policy u_policy (
        .zone    (zone),
        .asr_en  (asr_en),
        .srt_en  (srt_en),
        .permit  (sr_permit),
        .rec_asr (rec_asr),
        .rec_srt (rec_srt)
    );

    // Purpose: expose the rate selection
    assign fast_rate = zone.hot;
endmodule

// File: rtl/refresh_governor_chk.sv
// Module: refresh_governor_chk
// Property checker bound to refresh_governor. Tracks the gap since the
// last tick with its own counter, so that the window stays short.
module refresh_governor_chk #(
    parameter int unsigned CLK_KHZ         = 125000,
    parameter int unsigned PERIOD_MS       = 64,
    parameter int unsigned CMDS_PER_PERIOD = 8192,
    parameter int unsigned TEMP_W          = 8,
    parameter int unsigned HOT_C           = 85
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TEMP_W-1:0] temp_c,
    input logic              asr_en,
    input logic              srt_en,
    input logic              ref_tick,
    input logic              fast_rate,
    input logic              sr_permit,
    input logic              over_range,
    input logic              rec_srt
);
    localparam int unsigned NORM = (CLK_KHZ * PERIOD_MS) / CMDS_PER_PERIOD;
    localparam int unsigned GW   = $clog2(NORM + 2) + 1;

    logic [GW-1:0] gap_q;

    // Purpose: count clocks since reset or the last tick
    always_ff @(posedge clk) begin
        if (!rst_n)        gap_q <= '0;
        else if (ref_tick) gap_q <= GW'(1);
        else               gap_q <= gap_q + 1'b1;
    end

    // R2: pulses are one clock wide
    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> !ref_tick);

    // R2: never more than NORM clocks without a tick
    p_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == GW'(NORM - 1) && !ref_tick) |=> ref_tick);

    // R6: the hot flag only rises after a hot reading
    p_hot_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fast_rate) |-> ($past(temp_c) > TEMP_W'(HOT_C)));

    // R7: hot with no covering mode bit blocks self-refresh
    p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_rate && !asr_en && !srt_en) |-> !sr_permit);

    // R8: extended-range recommendation is zero under automatic mode
    p_srt_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        asr_en |-> !rec_srt);

    // R9: over-range error is sticky
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        over_range |=> over_range);
endmodule

bind refresh_governor refresh_governor_chk #(
    .CLK_KHZ         (CLK_KHZ),
    .PERIOD_MS       (PERIOD_MS),
    .CMDS_PER_PERIOD (CMDS_PER_PERIOD),
    .TEMP_W          (TEMP_W),
    .HOT_C           (HOT_C)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .temp_c     (temp_c),
    .asr_en     (asr_en),
    .srt_en     (srt_en),
    .ref_tick   (ref_tick),
    .fast_rate  (fast_rate),
    .sr_permit  (sr_permit),
    .over_range (over_range),
    .rec_srt    (rec_srt)
);

// File: tb/sim_refresh_governor.sv
// Bench: small configuration (NORM = 8, FAST = 4 clocks), phase sweep of
// temperature steps and an exhaustive temperature x mode-bit sweep.
module sim_refresh_governor;
    localparam int NORM = 8;
    localparam int FAST = NORM / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] temp_c = 8'd25;
    logic       asr_en = 1'b0;
    logic       srt_en = 1'b0;
    logic       ref_tick, fast_rate, sr_permit, over_range, rec_asr, rec_srt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    refresh_governor #(
        .CLK_KHZ         (1),
        .PERIOD_MS       (64),
        .CMDS_PER_PERIOD (8)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_c     (temp_c),
        .asr_en     (asr_en),
        .srt_en     (srt_en),
        .ref_tick   (ref_tick),
        .fast_rate  (fast_rate),
        .sr_permit  (sr_permit),
        .over_range (over_range),
        .rec_asr    (rec_asr),
        .rec_srt    (rec_srt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count falling edges until ref_tick is seen high
    task automatic next_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ref_tick && n < 4 * NORM);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 tick in reset", int'(ref_tick), 0);
        check("R1 over_range in reset", int'(over_range), 0);
        check("R1 fast_rate in reset", int'(fast_rate), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        int n;
        int exp;
        bit seen_over;
        temp_c = 8'd25;
        do_reset();
        next_tick(n);
        check("R1 first tick", n, NORM);
        next_tick(n);
        check("R2 cold gap", n, NORM);
        next_tick(n);
        check("R2 cold gap", n, NORM);

        // R4/R3/R5 phase sweep; starts at a tick, cold
        for (int j = 1; j < NORM; j++) begin
            repeat (j - 1) @(negedge clk);
            temp_c = 8'd90;
            next_tick(n);
            exp = (j + FAST + 1 < NORM) ? j + FAST + 1 : NORM;
            check($sformatf("R4 step phase %0d", j), n + j - 1, exp);
            next_tick(n);
            check("R3 hot gap", n, FAST);
            temp_c = 8'd30;
            next_tick(n);
            check("R5 cooling finishes fast", n, FAST);
            next_tick(n);
            check("R5 normal after cooling", n, NORM);
        end

        // Exhaustive temperature x mode-bit sweep (R6 R7 R8 R9)
        do_reset();
        seen_over = 1'b0;
        for (int t = 0; t <= 120; t++) begin
            for (int m = 0; m < 4; m++) begin
                @(negedge clk);
                temp_c = 8'(t);
                asr_en = m[0];
                srt_en = m[1];
                @(negedge clk);
                if (t > 95) seen_over = 1'b1;
                check("R6 fast_rate", int'(fast_rate), int'(t > 85));
                check("R7 sr_permit", int'(sr_permit),
                      int'(!(t > 95) && (t <= 85 || m[0] || m[1])));
                check("R8 rec_asr", int'(rec_asr), int'(m[0]));
                check("R8 rec_srt", int'(rec_srt), int'(!m[0] && t > 85));
                check("R9 over_range", int'(over_range), int'(seen_over));
            end
        end
        temp_c = 8'd40;
        @(negedge clk);
        @(negedge clk);
        check("R9 sticky after cooling", int'(over_range), 1);
        do_reset();
        @(negedge clk);
        check("R9 cleared by reset", int'(over_range), 0);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=done", cyc);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule